// File: doc/BRIEF.md
# Pipeline Control Staging Chain

This block moves the decoded control bits of each instruction through the later stages of a five-stage in-order pipeline together with that instruction. The decoder produces the whole control word once, while the instruction sits in the register-read/decode stage. From then on the word travels through the stage registers. The execute stage, the memory stage and the writeback stage each see only the bits of the instruction that is in that stage at that moment.

Stalls and flushes are handled here as well. A stall request freezes the program counter and the fetch/decode register, so the same instruction is fetched again and decoded again. In the same cycle an all-zero word enters execute as a bubble. A flush request empties the fetch/decode stage on the next clock, so whatever the decoder shows in the following cycle never enters execute. The decoder, the datapath and the memories are outside this block. They connect to it through the ports below.

Top module: `pipeCtrlChain`

## Requirements
- R1: With no stall and a live decode stage, the execute-group outputs show the decoded word one clock after the decode cycle. The execute group is {extend mode, ALU op, ALU source select, destination select}.
- R2: The memory-group outputs show the same instruction's memory write enable and branch bits two clocks after its decode cycle.
- R3: The writeback-group outputs show the same instruction's memory-to-register select and register write enable three clocks after its decode cycle.
- R4: `pcHold` and `fdHold` follow `stallReq` in the same cycle, with no register in between.
- R5: A decode cycle with `stallReq` high puts an all-zero word into execute. On the next clock every execute-group output is 0.
- R6: `flushReq` high in cycle n empties the fetch/decode stage. The decoder word in cycle n+1 is ignored, and the execute group is all zero in cycle n+2. A flush also clears a stalled fetch/decode stage, and the stage stays empty until it advances without a stall.
- R7: Reset, active low, clears every stage register, so all control outputs are 0. It also marks the fetch/decode stage as empty, so the decoder word in the first cycle after reset is ignored.
- R8: During a stall the memory and writeback stages keep advancing. An instruction already in execute still reaches memory and writeback on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stallReq | input | 1 | Hold the front end and insert a bubble |
| flushReq | input | 1 | Empty the fetch/decode stage on the next clock |
| decExtMode | input | EXT_W | Decoded immediate extend mode |
| decAluOp | input | ALU_OP_W | Decoded ALU operation |
| decAluSrc | input | 1 | Decoded ALU second-operand select |
| decDstSel | input | DST_SEL_W | Decoded destination register select |
| decMemWrite | input | 1 | Decoded data memory write enable |
| decBranch | input | 1 | Decoded branch flag |
| decMemToReg | input | 1 | Decoded writeback source select |
| decRegWrite | input | 1 | Decoded register write enable |
| exExtMode | output | EXT_W | Extend mode for the instruction in execute |
| exAluOp | output | ALU_OP_W | ALU operation in execute |
| exAluSrc | output | 1 | ALU source select in execute |
| exDstSel | output | DST_SEL_W | Destination select in execute |
| memWriteEn | output | 1 | Memory write enable in the memory stage |
| memBranch | output | 1 | Branch flag in the memory stage |
| wbMemToReg | output | 1 | Writeback source select in writeback |
| wbRegWrite | output | 1 | Register write enable in writeback |
| pcHold | output | 1 | Keep the program counter unchanged |
| fdHold | output | 1 | Keep the fetch/decode register unchanged |

## Verification
The bound checker looks at every clock for the following: the word captured into execute after a live decode cycle, the bubble after every stall, the empty execute slot two clocks after a flush, the hand-over from each stage to the next, and the hold outputs that follow a stall. Three things come only from the bench scenarios: the empty first decode cycle after reset, a flush arriving together with a stall, and an instruction that reaches memory and writeback intact during a long stall. These are shown by directed sequences and then by long random runs of mixed stalls and flushes, compared against a bench model of the stages.

// File: rtl/pipeCtrlPkg.sv
package pipeCtrlPkg;

  // Widths of the stage groups that have a fixed layout
  localparam int MEM_GRP_W = 2;  // {memWrite, branch}
  localparam int WB_GRP_W  = 2;  // {memToReg, regWrite}
  localparam int TAIL_W    = MEM_GRP_W + WB_GRP_W;

  // Strobes from the hazard control to the stage datapath
  typedef struct packed {
    logic pcHold;    // freeze program counter
    logic fdHold;    // freeze fetch/decode register
    logic fdKill;    // fetch/decode stage holds no instruction
    logic exInject;  // load a zero word into execute
  } ctrlStrobes_t;

endpackage

// File: rtl/ctrlStageReg.sv
module ctrlStageReg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         zeroLoad,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] qOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         qOut <= '0;
    else if (zeroLoad) qOut <= '0;
    else               qOut <= dIn;
  end

endmodule

// File: rtl/pipeHazardCtrl.sv
module pipeHazardCtrl
  import pipeCtrlPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         stallReq,
  input  logic         flushReq,
  output ctrlStrobes_t strobes
);

  // High while the fetch/decode register is empty (after reset or a flush)
  logic fdEmptyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         fdEmptyQ <= 1'b1;
    else if (flushReq) fdEmptyQ <= 1'b1;      // clearing beats holding
    else if (stallReq) fdEmptyQ <= fdEmptyQ;  // held register keeps its state
    else               fdEmptyQ <= 1'b0;      // fresh instruction arrives
  end

  always_comb begin
    strobes.pcHold   = stallReq;
    strobes.fdHold   = stallReq;
    strobes.fdKill   = fdEmptyQ;
    strobes.exInject = stallReq | fdEmptyQ;
  end

endmodule

// File: rtl/pipeCtrlStages.sv
module pipeCtrlStages
  import pipeCtrlPkg::*;
#(
  parameter int EX_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [EX_W+TAIL_W-1:0] decWord,
  output logic [EX_W+TAIL_W-1:0] idExQ,
  output logic [TAIL_W-1:0]      exMemQ,
  output logic [WB_GRP_W-1:0]    memWbQ
);

  localparam int TOT_W = EX_W + TAIL_W;

  // Decode to execute: the full word, or a bubble
  ctrlStageReg #(.W(TOT_W)) idExReg (
    .clk(clk), .rstN(rstN),
    .zeroLoad(strobes.exInject),
    .dIn(decWord), .qOut(idExQ)
  );

  // Execute to memory: the memory and writeback groups keep moving
  ctrlStageReg #(.W(TAIL_W)) exMemReg (
    .clk(clk), .rstN(rstN),
    .zeroLoad(1'b0),
    .dIn(idExQ[TAIL_W-1:0]), .qOut(exMemQ)
  );

  // Memory to writeback
  ctrlStageReg #(.W(WB_GRP_W)) memWbReg (
    .clk(clk), .rstN(rstN),
    .zeroLoad(1'b0),
    .dIn(exMemQ[WB_GRP_W-1:0]), .qOut(memWbQ)
  );

endmodule

// File: rtl/pipeCtrlChain.sv
module pipeCtrlChain
  import pipeCtrlPkg::*;
#(
  parameter int EXT_W     = 1,
  parameter int ALU_OP_W  = 4,
  parameter int DST_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stallReq,
  input  logic                 flushReq,
  input  logic [EXT_W-1:0]     decExtMode,
  input  logic [ALU_OP_W-1:0]  decAluOp,
  input  logic                 decAluSrc,
  input  logic [DST_SEL_W-1:0] decDstSel,
  input  logic                 decMemWrite,
  input  logic                 decBranch,
  input  logic                 decMemToReg,
  input  logic                 decRegWrite,
  output logic [EXT_W-1:0]     exExtMode,
  output logic [ALU_OP_W-1:0]  exAluOp,
  output logic                 exAluSrc,
  output logic [DST_SEL_W-1:0] exDstSel,
  output logic                 memWriteEn,
  output logic                 memBranch,
  output logic                 wbMemToReg,
  output logic                 wbRegWrite,
  output logic                 pcHold,
  output logic                 fdHold
);

  localparam int EX_W  = EXT_W + ALU_OP_W + 1 + DST_SEL_W;
  localparam int TOT_W = EX_W + TAIL_W;

  ctrlStrobes_t          strobes;
  logic [TOT_W-1:0]      decWord;
  logic [TOT_W-1:0]      idExQ;
  logic [TAIL_W-1:0]     exMemQ;
  logic [WB_GRP_W-1:0]   memWbQ;

  assign decWord = {decExtMode, decAluOp, decAluSrc, decDstSel,
                    decMemWrite, decBranch, decMemToReg, decRegWrite};

  pipeHazardCtrl hazCtrl (
    .clk(clk), .rstN(rstN),
    .stallReq(stallReq), .flushReq(flushReq),
    .strobes(strobes)
  );

  pipeCtrlStages #(.EX_W(EX_W)) stages (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .decWord(decWord),
    .idExQ(idExQ), .exMemQ(exMemQ), .memWbQ(memWbQ)
  );

  assign {exExtMode, exAluOp, exAluSrc, exDstSel} = idExQ[TOT_W-1:TAIL_W];
  assign {memWriteEn, memBranch} = exMemQ[TAIL_W-1:WB_GRP_W];
  assign {wbMemToReg, wbRegWrite} = memWbQ;
  assign pcHold = strobes.pcHold;
  assign fdHold = strobes.fdHold;

endmodule

// File: rtl/pipeCtrlChainChk.sv
module pipeCtrlChainChk #(
  parameter int TOT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             stallReq,
  input logic             flushReq,
  input logic             fdKill,
  input logic             pcHold,
  input logic             fdHold,
  input logic [TOT_W-1:0] decWord,
  input logic [TOT_W-1:0] idExQ,
  input logic [3:0]       exMemQ,
  input logic [1:0]       memWbQ
);

  AST_EX_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!stallReq && !fdKill) |=> (idExQ == $past(decWord))); // R1

  AST_MEM_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (exMemQ == $past(idExQ[3:0]))); // R2

  AST_WB_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (memWbQ == $past(exMemQ[1:0]))); // R3

  AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> (pcHold && fdHold)); // R4

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |=> (idExQ == '0)); // R5

  AST_FLUSH_KILL: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> ##1 (idExQ == '0)); // R6

  AST_STALL_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |=> (memWbQ == $past(exMemQ[1:0]))); // R8

endmodule

bind pipeCtrlChain pipeCtrlChainChk #(.TOT_W(TOT_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .stallReq(stallReq), .flushReq(flushReq),
  .fdKill(strobes.fdKill),
  .pcHold(pcHold), .fdHold(fdHold),
  .decWord(decWord), .idExQ(idExQ),
  .exMemQ(exMemQ), .memWbQ(memWbQ)
);

// File: tb/pipeCtrlChain_tb_top.sv
module pipeCtrlChain_tb_top;

  localparam int EX_W  = 8;   // 1 + 4 + 1 + 2
  localparam int TOT_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stallReq = 1'b0, flushReq = 1'b0;
  logic [TOT_W-1:0] drvWord = '0;

  logic       exExtMode, exAluSrc, memWriteEn, memBranch;
  logic       wbMemToReg, wbRegWrite, pcHold, fdHold;
  logic [3:0] exAluOp;
  logic [1:0] exDstSel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the stages
  logic [TOT_W-1:0] mIdEx;
  logic [3:0]       mExMem;
  logic [1:0]       mMemWb;
  logic             mEmpty;

  always #4 clk = ~clk;

  pipeCtrlChain dut_i (
    .clk(clk), .rstN(rstN), .stallReq(stallReq), .flushReq(flushReq),
    .decExtMode(drvWord[11]), .decAluOp(drvWord[10:7]), .decAluSrc(drvWord[6]),
    .decDstSel(drvWord[5:4]), .decMemWrite(drvWord[3]), .decBranch(drvWord[2]),
    .decMemToReg(drvWord[1]), .decRegWrite(drvWord[0]),
    .exExtMode(exExtMode), .exAluOp(exAluOp), .exAluSrc(exAluSrc),
    .exDstSel(exDstSel), .memWriteEn(memWriteEn), .memBranch(memBranch),
    .wbMemToReg(wbMemToReg), .wbRegWrite(wbRegWrite),
    .pcHold(pcHold), .fdHold(fdHold)
  );

  function automatic logic [EX_W-1:0] exOut();
    return {exExtMode, exAluOp, exAluSrc, exDstSel};
  endfunction

  function automatic logic [EX_W-1:0] expEx(input logic [TOT_W-1:0] w);
    return w[TOT_W-1:4];
  endfunction

  function automatic logic [TOT_W-1:0] nextIdEx(input logic s, input logic empty,
                                                input logic [TOT_W-1:0] w);
    return (s || empty) ? '0 : w;
  endfunction

  function automatic logic nextEmpty(input logic s, input logic f, input logic empty);
    if (f) return 1'b1;
    if (s) return empty;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkStages();
    chk("R1 execute group", 16'(exOut()), 16'(expEx(mIdEx)));
    chk("R2 memory group", 16'({memWriteEn, memBranch}), 16'(mExMem[3:2]));
    chk("R3 writeback group", 16'({wbMemToReg, wbRegWrite}), 16'(mMemWb));
  endtask

  // Called just after a falling edge; returns after the next falling edge
  task automatic stepCycle(input logic s, input logic f, input logic [TOT_W-1:0] w);
    logic [TOT_W-1:0] nIdEx;
    logic [3:0] nExMem;
    logic [1:0] nMemWb;
    logic nEmpty;
    stallReq = s; flushReq = f; drvWord = w;
    #1;
    chk("R4 pcHold", 16'(pcHold), 16'(s));
    chk("R4 fdHold", 16'(fdHold), 16'(s));
    nIdEx  = nextIdEx(s, mEmpty, w);
    nExMem = mIdEx[3:0];
    nMemWb = mExMem[1:0];
    nEmpty = nextEmpty(s, f, mEmpty);
    @(posedge clk);
    mIdEx = nIdEx; mExMem = nExMem; mMemWb = nMemWb; mEmpty = nEmpty;
    @(negedge clk);
    checkStages();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TOT_W-1:0] wa, wb, wc;
    void'($urandom(32'd1357));
    mIdEx = '0; mExMem = '0; mMemWb = '0; mEmpty = 1'b1;

    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 reset execute", 16'(exOut()), 16'h0);
    chk("R7 reset memory", 16'({memWriteEn, memBranch}), 16'h0);
    chk("R7 reset writeback", 16'({wbMemToReg, wbRegWrite}), 16'h0);
    rstN = 1'b1;

    // R7: first decode word after reset is ignored
    stepCycle(1'b0, 1'b0, '1);
    chk("R7 first word ignored", 16'(exOut()), 16'h0);

    // R1/R5/R8: instruction A then a two-cycle stall
    wa = 12'hABF; wb = 12'h5C3;
    stepCycle(1'b0, 1'b0, wa);
    chk("R1 A in execute", 16'(exOut()), 16'(expEx(wa)));
    stepCycle(1'b1, 1'b0, wb);
    chk("R5 bubble after stall", 16'(exOut()), 16'h0);
    chk("R8 A reaches memory", 16'({memWriteEn, memBranch}), 16'(wa[3:2]));
    stepCycle(1'b1, 1'b0, wb);
    chk("R5 second bubble", 16'(exOut()), 16'h0);
    chk("R8 A reaches writeback", 16'({wbMemToReg, wbRegWrite}), 16'(wa[1:0]));
    stepCycle(1'b0, 1'b0, wb);
    chk("R1 B after stall", 16'(exOut()), 16'(expEx(wb)));

    // R6: flush empties the stage
    wc = 12'h7E6;
    stepCycle(1'b0, 1'b1, wc);
    chk("R6 flush cycle word kept", 16'(exOut()), 16'(expEx(wc)));
    stepCycle(1'b0, 1'b0, '1);
    chk("R6 flushed slot empty", 16'(exOut()), 16'h0);
    stepCycle(1'b0, 1'b0, wa);
    chk("R6 recovery", 16'(exOut()), 16'(expEx(wa)));

    // R6: flush together with stall, then stay stalled
    stepCycle(1'b1, 1'b1, wb);
    chk("R6 stall+flush bubble", 16'(exOut()), 16'h0);
    stepCycle(1'b1, 1'b0, wb);
    chk("R6 empty stage held", 16'(exOut()), 16'h0);
    stepCycle(1'b0, 1'b0, wb);
    chk("R6 empty stage released", 16'(exOut()), 16'h0);
    stepCycle(1'b0, 1'b0, wc);
    chk("R6 live again", 16'(exOut()), 16'(expEx(wc)));

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      stepCycle(($urandom % 5) == 0, ($urandom % 8) == 0, TOT_W'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule